// File: doc/BRIEF.md
# Hexadecimal floating-point divider

This block divides one base-16 floating-point number by another and returns the normalized quotient, truncated to the length of the selected format. A word holds a sign bit, a 7-bit excess-64 characteristic and a fraction of hexadecimal digits. The fraction is 56 bits in the long format and 24 bits in the short format. A short operand sits in the upper half of the 64-bit operand port. The block accepts a one-cycle `start` pulse together with both operands, a format select, an exponent-underflow mask bit and the two register designators of the instruction. Some time later it pulses `done` for one cycle. In that same cycle it drives the result flags and a write strobe for the destination. No remainder is produced, and no condition code is touched.

A state machine sequences the operation through five states:
- S_IDLE waits for `start`. Its transitions are *accept* (to S_NORM) and *early* (to S_EARLY, taken on a bad register designator, a zero divisor fraction or a zero dividend fraction).
- S_NORM removes one leading zero hex digit per cycle from each operand that still has one. Its transition *normalized* goes to S_DIVIDE.
- S_DIVIDE runs a restoring fraction divider that produces one quotient bit per cycle. Its transition *quotient_ready* goes to S_PACK.
- S_PACK forms the characteristic, applies the overflow and underflow rules and emits the result. Its transition *finish* returns to S_IDLE.
- S_EARLY reports a suppressed operation or a true zero. Its transition *finish* also returns to S_IDLE.

Top module: `hfp_divider`

## Requirements
- R1: A register designator is valid only when its value is 0, 2, 4 or 6. `r1_sel` is always checked, and `r2_sel` is checked only when `reg_form` is 1. An invalid designator raises `spec_err` with `done`, leaves `q_wr` low and `quotient` unchanged, and takes priority over `div_zero`.
- R2: A zero divisor fraction raises `div_zero` with `done` and suppresses the write: `q_wr` stays low and `quotient` keeps its previous value. This includes a zero dividend divided by a zero divisor.
- R3: A zero dividend fraction with a nonzero divisor fraction writes a true zero (all 64 bits zero) and raises no flag.
- R4: For nonzero operands, the result sign is the XOR of the operand signs. The result fraction is the quotient of the normalized fractions, and its leading hex digit is nonzero. The characteristic is (normalized dividend exponent) − (normalized divisor exponent) + 64, plus one when the raw quotient is 1 or more and the fraction is shifted right by one hex digit.
- R5: When the final characteristic exceeds 127, `exp_ovf` is raised and the delivered characteristic is 128 less than the true value. Sign and fraction stay correct.
- R6: When the final characteristic is below 0 and `uf_mask` is 1, `exp_unf` is raised and the delivered characteristic is 128 more than the true value.
- R7: When the final characteristic is below 0 and `uf_mask` is 0, a true zero (positive sign, all bits zero) is written and no flag is raised.
- R8: Unnormalized operands are normalized before division, one hex digit per leading zero. The exponent may become negative during this step without any underflow, provided the final quotient is representable.
- R9: Short format (`fmt_long`=0) uses bit 63 as the sign, bits 62:56 as the characteristic and bits 55:32 as the 24-bit fraction. Bits 31:0 of the operands are ignored, and bits 31:0 of the result are written as zero.
- R10: Long format (`fmt_long`=1) uses bit 63 as the sign, bits 62:56 as the characteristic and bits 55:0 as the 56-bit fraction.
- R11: Every accepted `start` yields exactly one single-cycle `done` pulse. `q_wr`, `exp_ovf`, `exp_unf`, `div_zero` and `spec_err` are asserted only together with `done`.
- R12: The result fraction is truncated, not rounded: digits beyond the format length are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a divide; sampled in S_IDLE only |
| fmt_long | input | 1 | 1 = long format, 0 = short format |
| uf_mask | input | 1 | Exponent-underflow mask bit |
| reg_form | input | 1 | 1 when the second operand came from a register, which enables the `r2_sel` check |
| r1_sel | input | 4 | First-operand register designator |
| r2_sel | input | 4 | Second-operand register designator |
| dividend | input | 64 | Dividend word |
| divisor | input | 64 | Divisor word |
| done | output | 1 | One-cycle completion pulse |
| q_wr | output | 1 | Destination write strobe, valid with `done` |
| quotient | output | 64 | Result word; holds its value when no write occurs |
| exp_ovf | output | 1 | Exponent overflow flag |
| exp_unf | output | 1 | Exponent underflow flag |
| div_zero | output | 1 | Divide-by-zero flag (operation suppressed) |
| spec_err | output | 1 | Specification flag (operation suppressed) |

## Verification
The directed cases each isolate one rule:
- Exact quotients such as 1/2 and 2/3 show whether the fraction is truncated or rounded, and whether the one-digit right shift is applied.
- Operands with leading zero digits, including one whose intermediate exponent goes negative, show whether pre-normalization adjusts the exponent and whether it falsely reports underflow.
- Extreme characteristics under both mask values separate the wrap-by-128 path from the forced true zero.
- Invalid designators combined with a zero divisor show the priority between the two suppressing checks.

Randomly drawn operands mix the two formats, random signs and up to three leading zero digits, with characteristics biased toward both ends of the range. These are compared against a wide-integer division model, which exercises the general quotient path and the flag conditions together.

// File: rtl/hfp_pkg.sv
package hfp_pkg;

    localparam int EXP_W   = 7;
    localparam int LFRAC_W = 56;
    localparam int SFRAC_W = 24;

    typedef enum logic [2:0] {
        S_IDLE,
        S_NORM,
        S_DIVIDE,
        S_PACK,
        S_EARLY
    } div_state_t;

    typedef enum logic [1:0] {
        EK_SPEC,
        EK_DZERO,
        EK_TZERO
    } early_kind_t;

    typedef enum logic {
        C_IDLE,
        C_RUN
    } core_state_t;

    // A floating-point register designator is usable when even and at most 6.
    function automatic logic fpr_ok(input logic [3:0] sel);
        return (sel[0] == 1'b0) && (sel[3] == 1'b0);
    endfunction

endpackage

// File: rtl/hfp_div_unpack.sv
module hfp_div_unpack #(
    parameter int EW = 7,
    parameter int FW = 56,
    parameter int SW = 24,
    localparam int W = 1 + EW + FW
) (
    input  logic [W-1:0]  word,
    input  logic          fmt_long,
    output logic          sign,
    output logic [EW-1:0] chr,
    output logic [FW-1:0] frac,
    output logic          frac_zero
);

    // Sign and characteristic occupy the same bits in both formats.
    assign sign = word[W-1];
    assign chr  = word[W-2 -: EW];

    // A short fraction is aligned to the top of the long fraction field.
    always_comb begin
        if (fmt_long) begin
            frac = word[FW-1:0];
        end else begin
            frac = {word[FW-1 -: SW], {(FW-SW){1'b0}}};
        end
    end

    assign frac_zero = (frac == '0);

endmodule

// File: rtl/hfp_div_frac_core.sv
module hfp_div_frac_core #(
    parameter int FW = 56,
    localparam int QW = FW + 4,
    localparam int CW = $clog2(QW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [CW-1:0] n_bits,
    input  logic [FW-1:0] num,
    input  logic [FW-1:0] den,
    output logic          fin,
    output logic [QW-1:0] quo
);
    import hfp_pkg::*;

    core_state_t   cst_q;
    logic [FW-1:0] rem_q;
    logic [QW-1:0] feed_q;
    logic [CW-1:0] cnt_q;

    logic [FW:0]   trial;
    logic [FW:0]   diff;
    logic          fits;
    logic [FW-1:0] rem_nxt;

    // One restoring step: shift in the next numerator bit, subtract if it fits.
    always_comb begin
        trial   = {rem_q, feed_q[QW-1]};
        diff    = trial - {1'b0, den};
        fits    = (trial >= {1'b0, den});
        rem_nxt = fits ? diff[FW-1:0] : trial[FW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cst_q  <= C_IDLE;
            rem_q  <= '0;
            feed_q <= '0;
            cnt_q  <= '0;
            quo    <= '0;
            fin    <= 1'b0;
        end else begin
            fin <= 1'b0;
            unique case (cst_q)
                C_IDLE: begin
                    if (go) begin
                        cst_q  <= C_RUN;
                        // numerator is num * 2^(n_bits-4): top part seeds the remainder
                        rem_q  <= {4'b0000, num[FW-1:4]};
                        feed_q <= {num[3:0], {(QW-4){1'b0}}};
                        cnt_q  <= n_bits;
                        quo    <= '0;
                    end
                end
                C_RUN: begin
                    rem_q  <= rem_nxt;
                    feed_q <= {feed_q[QW-2:0], 1'b0};
                    quo    <= {quo[QW-2:0], fits};
                    cnt_q  <= cnt_q - 1'b1;
                    if (cnt_q == CW'(1)) begin
                        cst_q <= C_IDLE;
                        fin   <= 1'b1;
                    end
                end
                default: cst_q <= C_IDLE;
            endcase
        end
    end

    // R4: partial remainder stays below the divisor throughout the loop
    p_rem_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cst_q == C_RUN) |-> (rem_q < den));

endmodule

// File: rtl/hfp_div_pack.sv
module hfp_div_pack #(
    parameter int EW = 7,
    parameter int FW = 56,
    parameter int SW = 24,
    localparam int W  = 1 + EW + FW,
    localparam int QW = FW + 4,
    localparam int XW = EW + 3
) (
    input  logic                 sign,
    input  logic signed [XW-1:0] exp_a,
    input  logic signed [XW-1:0] exp_b,
    input  logic [QW-1:0]        quo,
    input  logic                 fmt_long,
    input  logic                 uf_mask,
    output logic [W-1:0]         word,
    output logic                 ovf,
    output logic                 unf
);

    localparam int BIAS = 2 ** (EW - 1);
    localparam int MAXE = 2 ** EW - 1;

    logic                 int_nz;
    logic [FW-1:0]        frac;
    logic [SW-1:0]        sfrac;
    logic signed [XW-1:0] exp_raw;

    always_comb begin
        // Raw quotient lies in (1/16, 16); a nonzero integer digit means shift right.
        int_nz = fmt_long ? (quo[FW+3:FW] != 4'h0) : (quo[SW+3:SW] != 4'h0);
        sfrac  = int_nz ? quo[SW+3:4] : quo[SW-1:0];
        if (fmt_long) begin
            frac = int_nz ? quo[FW+3:4] : quo[FW-1:0];
        end else begin
            frac = {sfrac, {(FW-SW){1'b0}}};
        end

        exp_raw = exp_a - exp_b + $signed(XW'(BIAS))
                + $signed({{(XW-1){1'b0}}, int_nz});

        ovf  = 1'b0;
        unf  = 1'b0;
        word = {sign, exp_raw[EW-1:0], frac};
        if (exp_raw > $signed(XW'(MAXE))) begin
            ovf = 1'b1;                  // wrap down by 2^EW (low bits unchanged)
        end else if (exp_raw < $signed(XW'(0))) begin
            if (uf_mask) begin
                unf = 1'b1;              // wrap up by 2^EW
            end else begin
                word = '0;               // true zero, positive
            end
        end
    end

endmodule

// File: rtl/hfp_divider.sv
module hfp_divider #(
    parameter int EW = hfp_pkg::EXP_W,
    parameter int FW = hfp_pkg::LFRAC_W,
    parameter int SW = hfp_pkg::SFRAC_W,
    localparam int W  = 1 + EW + FW,
    localparam int XW = EW + 3,
    localparam int QW = FW + 4,
    localparam int CW = $clog2(QW + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         fmt_long,
    input  logic         uf_mask,
    input  logic         reg_form,
    input  logic [3:0]   r1_sel,
    input  logic [3:0]   r2_sel,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic         q_wr,
    output logic [W-1:0] quotient,
    output logic         exp_ovf,
    output logic         exp_unf,
    output logic         div_zero,
    output logic         spec_err
);
    import hfp_pkg::*;

    div_state_t  state_q, state_d;
    early_kind_t early_q;

    logic                 fmt_q, mask_q, sign_q;
    logic [FW-1:0]        na_q, nb_q;
    logic signed [XW-1:0] ea_q, eb_q;

    logic          ua_sign, ub_sign, ua_zero, ub_zero;
    logic [EW-1:0] ua_chr, ub_chr;
    logic [FW-1:0] ua_frac, ub_frac;

    logic          spec_bad;
    logic          a_norm, b_norm, core_go, core_fin;
    logic [CW-1:0] core_bits;
    logic [QW-1:0] core_quo;
    logic [W-1:0]  pk_word;
    logic          pk_ovf, pk_unf;

    hfp_div_unpack #(.EW(EW), .FW(FW), .SW(SW)) u_unp_a (
        .word(dividend), .fmt_long(fmt_long), .sign(ua_sign),
        .chr(ua_chr), .frac(ua_frac), .frac_zero(ua_zero)
    );

    hfp_div_unpack #(.EW(EW), .FW(FW), .SW(SW)) u_unp_b (
        .word(divisor), .fmt_long(fmt_long), .sign(ub_sign),
        .chr(ub_chr), .frac(ub_frac), .frac_zero(ub_zero)
    );

    assign spec_bad  = !fpr_ok(r1_sel) || (reg_form && !fpr_ok(r2_sel));
    assign a_norm    = (na_q[FW-1 -: 4] != 4'h0);
    assign b_norm    = (nb_q[FW-1 -: 4] != 4'h0);
    assign core_go   = (state_q == S_NORM) && a_norm && b_norm;
    assign core_bits = fmt_q ? CW'(QW) : CW'(SW + 4);

    hfp_div_frac_core #(.FW(FW)) u_core (
        .clk(clk), .rst_n(rst_n), .go(core_go), .n_bits(core_bits),
        .num(na_q), .den(nb_q), .fin(core_fin), .quo(core_quo)
    );

    hfp_div_pack #(.EW(EW), .FW(FW), .SW(SW)) u_pack (
        .sign(sign_q), .exp_a(ea_q), .exp_b(eb_q), .quo(core_quo),
        .fmt_long(fmt_q), .uf_mask(mask_q), .word(pk_word),
        .ovf(pk_ovf), .unf(pk_unf)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    if (spec_bad || ua_zero || ub_zero) state_d = S_EARLY; // early
                    else                                state_d = S_NORM;  // accept
                end
            end
            S_NORM:   if (a_norm && b_norm) state_d = S_DIVIDE;            // normalized
            S_DIVIDE: if (core_fin)         state_d = S_PACK;              // quotient_ready
            S_PACK:   state_d = S_IDLE;                                    // finish
            S_EARLY:  state_d = S_IDLE;                                    // finish
            default:  state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Operand capture and pre-normalization
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            early_q <= EK_SPEC;
            fmt_q   <= 1'b0;
            mask_q  <= 1'b0;
            sign_q  <= 1'b0;
            na_q    <= '0;
            nb_q    <= '0;
            ea_q    <= '0;
            eb_q    <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        if (spec_bad)     early_q <= EK_SPEC;
                        else if (ub_zero) early_q <= EK_DZERO;
                        else              early_q <= EK_TZERO;
                        fmt_q  <= fmt_long;
                        mask_q <= uf_mask;
                        sign_q <= ua_sign ^ ub_sign;
                        na_q   <= ua_frac;
                        nb_q   <= ub_frac;
                        ea_q   <= $signed({{(XW-EW){1'b0}}, ua_chr});
                        eb_q   <= $signed({{(XW-EW){1'b0}}, ub_chr});
                    end
                end
                S_NORM: begin
                    if (!a_norm) begin
                        na_q <= {na_q[FW-5:0], 4'h0};
                        ea_q <= ea_q - XW'(1);
                    end
                    if (!b_norm) begin
                        nb_q <= {nb_q[FW-5:0], 4'h0};
                        eb_q <= eb_q - XW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            q_wr     <= 1'b0;
            quotient <= '0;
            exp_ovf  <= 1'b0;
            exp_unf  <= 1'b0;
            div_zero <= 1'b0;
            spec_err <= 1'b0;
        end else begin
            done     <= 1'b0;
            q_wr     <= 1'b0;
            exp_ovf  <= 1'b0;
            exp_unf  <= 1'b0;
            div_zero <= 1'b0;
            spec_err <= 1'b0;
            unique case (state_q)
                S_PACK: begin
                    done     <= 1'b1;
                    q_wr     <= 1'b1;
                    quotient <= pk_word;
                    exp_ovf  <= pk_ovf;
                    exp_unf  <= pk_unf;
                end
                S_EARLY: begin
                    done <= 1'b1;
                    unique case (early_q)
                        EK_SPEC:  spec_err <= 1'b1;
                        EK_DZERO: div_zero <= 1'b1;
                        default: begin
                            q_wr     <= 1'b1;
                            quotient <= '0;
                        end
                    endcase
                end
                default: ;
            endcase
        end
    end

    // R11: flags and write strobe only accompany done
    p_flags_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q_wr || exp_ovf || exp_unf || div_zero || spec_err) |-> done);

    // R11: done is a single-cycle pulse
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1 / R2: suppressed operations leave the destination untouched
    p_suppress_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (div_zero || spec_err)) |-> (!q_wr && $stable(quotient)));

    // R1: specification check wins over divide-by-zero
    p_spec_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        spec_err |-> !div_zero);

    // R5 / R6: overflow and underflow never together
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(exp_ovf && exp_unf));

    // R4: a written nonzero result has a nonzero leading hex digit
    p_lead_digit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q_wr && (quotient != '0)) |-> (quotient[FW-1 -: 4] != 4'h0));

    // R7: a zero fraction is always written as a positive true zero
    p_true_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q_wr && (quotient[FW-1:0] == '0)) |-> (quotient == '0));

    // R9: short results have a clear low half
    p_short_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q_wr && !fmt_q) |-> (quotient[FW-SW-1:0] == '0));

endmodule

// File: tb/hfp_divider_tb.sv
`timescale 1ns/100ps
module hfp_divider_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        fmt_long = 1'b1;
    logic        uf_mask = 1'b0;
    logic        reg_form = 1'b0;
    logic [3:0]  r1_sel = 4'd0;
    logic [3:0]  r2_sel = 4'd0;
    logic [63:0] dividend = '0;
    logic [63:0] divisor = '0;
    logic        done, q_wr, exp_ovf, exp_unf, div_zero, spec_err;
    logic [63:0] quotient;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    logic [63:0] held = '0;

    always #2.5 clk = ~clk;

    hfp_divider u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .fmt_long(fmt_long),
        .uf_mask(uf_mask), .reg_form(reg_form), .r1_sel(r1_sel), .r2_sel(r2_sel),
        .dividend(dividend), .divisor(divisor), .done(done), .q_wr(q_wr),
        .quotient(quotient), .exp_ovf(exp_ovf), .exp_unf(exp_unf),
        .div_zero(div_zero), .spec_err(spec_err)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails  = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // Independent model: wide-integer division of normalized fractions.
    task automatic model(input logic [63:0] a, input logic [63:0] b, input bit lng,
                         input bit msk, input bit rf, input logic [3:0] s1,
                         input logic [3:0] s2, output logic [63:0] w, output bit wr,
                         output bit ov, output bit un, output bit dz, output bit sp,
                         output string tag);
        int F, ea, eb, ex;
        logic [127:0] fa, fb, q, fmask;
        bit sg;
        F  = lng ? 56 : 24;
        fa = lng ? {72'd0, a[55:0]} : {104'd0, a[55:32]};
        fb = lng ? {72'd0, b[55:0]} : {104'd0, b[55:32]};
        ea = int'(a[62:56]);
        eb = int'(b[62:56]);
        sg = a[63] ^ b[63];
        w = held; wr = 0; ov = 0; un = 0; dz = 0; sp = 0;
        tag = lng ? "R4" : "R9";
        if (!(s1 inside {4'd0, 4'd2, 4'd4, 4'd6}) ||
            (rf && !(s2 inside {4'd0, 4'd2, 4'd4, 4'd6}))) begin
            sp = 1; tag = "R1"; return;
        end
        if (fb == 0) begin dz = 1; tag = "R2"; return; end
        if (fa == 0) begin w = 0; wr = 1; tag = "R3"; return; end
        while ((fa >> (F - 4)) == 0) begin fa = fa << 4; ea = ea - 1; end
        while ((fb >> (F - 4)) == 0) begin fb = fb << 4; eb = eb - 1; end
        q  = (fa << F) / fb;
        ex = ea - eb + 64;
        if ((q >> F) != 0) begin q = q >> 4; ex = ex + 1; end
        fmask = (128'd1 << F) - 1;
        q = q & fmask;
        wr = 1;
        if (ex > 127) begin
            ov = 1; ex = ex - 128; tag = "R5";
        end else if (ex < 0) begin
            if (msk) begin un = 1; ex = ex + 128; tag = "R6"; end
            else begin w = 0; tag = "R7"; return; end
        end
        if (lng) w = {sg, 7'(ex), q[55:0]};
        else     w = {sg, 7'(ex), q[23:0], 32'd0};
    endtask

    task automatic run_op(input logic [63:0] a, input logic [63:0] b, input bit lng,
                          input bit msk, input bit rf, input logic [3:0] s1,
                          input logic [3:0] s2, input string note);
        logic [63:0] ew;
        bit ewr, eov, eun, edz, esp, seen;
        string tag;
        model(a, b, lng, msk, rf, s1, s2, ew, ewr, eov, eun, edz, esp, tag);
        @(negedge clk);
        dividend = a; divisor = b; fmt_long = lng; uf_mask = msk;
        reg_form = rf; r1_sel = s1; r2_sel = s2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seen = 0;
        for (int i = 0; i < 300; i++) begin
            if (done) begin seen = 1; break; end
            @(negedge clk);
        end
        checks = checks + 1;
        if (!seen) begin
            fails = fails + 1;
            $display("FAIL R11 %s: no done, actual 0 expected 1", note);
            return;
        end
        if (quotient !== ew || q_wr !== ewr || exp_ovf !== eov || exp_unf !== eun ||
            div_zero !== edz || spec_err !== esp) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual q=%h wr=%b ov=%b un=%b dz=%b sp=%b expected q=%h wr=%b ov=%b un=%b dz=%b sp=%b",
                     tag, note, quotient, q_wr, exp_ovf, exp_unf, div_zero, spec_err,
                     ew, ewr, eov, eun, edz, esp);
        end
        if (ewr) held = ew;
        @(negedge clk);
        checks = checks + 1;
        if (done !== 1'b0) begin
            fails = fails + 1;
            $display("FAIL R11 %s: done longer than one cycle, actual %b expected 0", note, done);
        end
    endtask

    task automatic expect_word(input logic [63:0] want, input string tag);
        checks = checks + 1;
        if (held !== want) begin
            fails = fails + 1;
            $display("FAIL %s directed: actual %h expected %h", tag, held, want);
        end
    endtask

    function automatic logic [63:0] gen_op(input bit lng, input int zero_pct);
        logic [63:0] t, g;
        logic [55:0] f;
        logic [6:0] c;
        t = {$urandom, $urandom};
        g = {$urandom, $urandom};
        f = t[55:0] >> (4 * ($urandom % 4));
        case ($urandom % 4)
            0: c = 7'($urandom % 16);
            1: c = 7'(112 + $urandom % 16);
            default: c = 7'($urandom % 128);
        endcase
        if (!lng) f = {32'd0, t[23:0] >> (4 * ($urandom % 4))};
        if (($urandom % 100) < zero_pct) f = '0;
        if (lng) return {g[63], c, f};
        return {g[63], c, f[23:0], g[31:0]};
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks = checks + 1;
        if (done !== 0 || q_wr !== 0 || quotient !== 0 || exp_ovf !== 0 ||
            exp_unf !== 0 || div_zero !== 0 || spec_err !== 0) begin
            fails = fails + 1;
            $display("FAIL R11 reset: actual done=%b q=%h expected 0", done, quotient);
        end

        // R10 / R4: 1/2 in long format -> 0x40 characteristic, fraction 0x8...
        run_op(64'h4110_0000_0000_0000, 64'h4120_0000_0000_0000, 1, 0, 1, 0, 2, "half");
        expect_word(64'h4080_0000_0000_0000, "R4");
        // R12: 2/3 truncated, not rounded
        run_op(64'h4120_0000_0000_0000, 64'h4130_0000_0000_0000, 1, 0, 1, 2, 4, "two_thirds");
        expect_word(64'h40AA_AAAA_AAAA_AAAA, "R12");
        // R5: overflow wraps characteristic down by 128
        run_op(64'h7F10_0000_0000_0000, 64'h0110_0000_0000_0000, 1, 0, 0, 4, 0, "ovf");
        expect_word(64'h3F10_0000_0000_0000, "R5");
        // R6: underflow with mask set wraps up by 128, sign negative
        run_op(64'h8010_0000_0000_0000, 64'h7F20_0000_0000_0000, 1, 1, 0, 6, 0, "unf_mask1");
        expect_word(64'hC180_0000_0000_0000, "R6");
        // R7: same operands with mask clear give a positive true zero
        run_op(64'h8010_0000_0000_0000, 64'h7F20_0000_0000_0000, 1, 0, 0, 6, 0, "unf_mask0");
        expect_word(64'h0, "R7");
        // R8: three leading zero digits in the dividend
        run_op(64'h4100_0100_0000_0000, 64'h4110_0000_0000_0000, 1, 0, 0, 0, 0, "prenorm");
        expect_word(64'h3E10_0000_0000_0000, "R8");
        // R8: intermediate exponent goes negative, result still representable
        run_op(64'h0100_0100_0000_0000, 64'h0120_0000_0000_0000, 1, 0, 0, 0, 0, "neg_interm");
        expect_word(64'h3D80_0000_0000_0000, "R8");
        // R9: short format, low half of operands is garbage
        run_op(64'h4110_0000_DEAD_BEEF, 64'h4120_0000_1234_5678, 0, 0, 1, 2, 2, "short_half");
        expect_word(64'h4080_0000_0000_0000, "R9");
        // R3: zero dividend
        run_op(64'hC500_0000_0000_0000, 64'h4130_0000_0000_0000, 1, 1, 0, 0, 0, "zero_dividend");
        expect_word(64'h0, "R3");
        // Seed a known destination value before the suppression cases
        run_op(64'h4110_0000_0000_0000, 64'h4120_0000_0000_0000, 1, 0, 0, 0, 0, "seed");
        // R2: zero divisor and zero over zero
        run_op(64'h4130_0000_0000_0000, 64'h4100_0000_0000_0000, 1, 0, 0, 0, 0, "div_by_zero");
        run_op(64'h4100_0000_0000_0000, 64'h4200_0000_0000_0000, 1, 0, 0, 0, 0, "zero_by_zero");
        expect_word(64'h4080_0000_0000_0000, "R2");
        // R1: odd and out-of-range designators, r2 ignored for storage forms
        run_op(64'h4110_0000_0000_0000, 64'h4120_0000_0000_0000, 1, 0, 0, 3, 0, "r1_odd");
        run_op(64'h4110_0000_0000_0000, 64'h4120_0000_0000_0000, 1, 0, 0, 8, 0, "r1_eight");
        run_op(64'h4110_0000_0000_0000, 64'h4120_0000_0000_0000, 1, 0, 1, 0, 5, "r2_odd_rr");
        run_op(64'h4110_0000_0000_0000, 64'h4130_0000_0000_0000, 1, 0, 0, 0, 5, "r2_odd_rx");
        // R1: specification wins over a zero divisor
        run_op(64'h4110_0000_0000_0000, 64'h4100_0000_0000_0000, 1, 0, 1, 2, 7, "spec_vs_dz");

        for (int n = 0; n < 400; n++) begin
            bit lng, rf;
            logic [3:0] s1, s2;
            lng = ($urandom % 2) == 1;
            rf  = ($urandom % 2) == 1;
            s1  = (($urandom % 12) == 0) ? 4'($urandom % 16) : 4'(2 * ($urandom % 4));
            s2  = (($urandom % 12) == 0) ? 4'($urandom % 16) : 4'(2 * ($urandom % 4));
            run_op(gen_op(lng, 5), gen_op(lng, 3), lng, ($urandom % 2) == 1, rf, s1, s2, "random");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule